// File: doc/BRIEF.md
# Peripheral-to-Memory Byte Mover

This block is one channel of a direct memory access engine that drains a peripheral's receive data register into a memory buffer. Each time the peripheral signals that a byte is waiting, the channel reads that byte from a fixed source address. It acknowledges the peripheral, so the peripheral can clear its data-waiting flag. It then writes the byte to the next location of the buffer. The buffer pointer advances by one after every byte. The source address never moves.

Software programs the source address, the buffer start address and the byte count, then sets the enable bit. The channel raises a half-way flag once half of the count has been moved, rounding up, and a done flag when the count runs out. Either flag can drive the interrupt line. Flags are cleared by writing ones to them. Once the count is zero the channel ignores further requests. While the channel is enabled, only the enable bit accepts writes, so a running transfer cannot be disturbed.

Top module: `dma_p2m_chan`

## Requirements
- R1: After reset every register reads as zero, and `mem_req`, `periph_ack` and `irq` are low.
- R2: With the enable bit (offset 0, bit 0) clear, a held request starts no bus access and no acknowledge.
- R3: Every bus read (`mem_we`=0) uses the programmed source address (offset 1), unchanged across bytes.
- R4: `periph_ack` is a single-cycle pulse in the cycle after the read is granted, and exactly one is given per byte.
- R5: Each byte is written (`mem_we`=1) to the current buffer pointer. The pointer then grows by one, and its readback (offset 2) shows the next address.
- R6: The remaining count (offset 3 read) drops by one per byte, and requests are ignored once it is zero.
- R7: The done flag (offset 4, bit 1) is set only when the last byte has been written.
- R8: The half flag (offset 4, bit 0) is set when the remaining count after a byte equals the programmed count divided by two, rounded down; for a count of one it rises with done.
- R9: `irq` is high while (half flag and half enable, offset 0 bit 1) or (done flag and done enable, offset 0 bit 2) holds.
- R10: Writing offset 4 clears each flag whose data bit is 1 and leaves the others.
- R11: While enabled, writes to offsets 1, 2 and 3 and to the non-enable fields of offset 0 have no effect; clearing the enable bit still takes effect.
- R12: The two-bit priority field (offset 0, bits 5:4) reads back as written while disabled.
- R13: While a bus request waits for `mem_gnt`, request, address and direction stay steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| periph_req | input | 1 | Peripheral has a byte waiting |
| periph_ack | output | 1 | Byte taken from peripheral |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_gnt` |
| mem_gnt | input | 1 | Bus access accepted this cycle |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is a held request after the count has run out. Right at that point the peripheral and the channel both still look ready, and only the zero remaining count should block a new read. The bench drives a full transfer to completion, holds the request high for many cycles and counts bus reads and acknowledges. Odd counts combined with bus wait states are used to confirm that the half-way flag rounds up.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_e;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_SRC  = 3'd1;
    localparam logic [2:0] OFS_DST  = 3'd2;
    localparam logic [2:0] OFS_CNT  = 3'd3;
    localparam logic [2:0] OFS_STAT = 3'd4;

    localparam int BIT_EN   = 0;
    localparam int BIT_HIE  = 1;
    localparam int BIT_DIE  = 2;
    localparam int BIT_PRLO = 4;
    localparam int BIT_HALF = 0;
    localparam int BIT_DONE = 1;
endpackage

// File: rtl/dmac_cfg.sv
module dmac_cfg
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          byte_done,
    output logic          en,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] rem,
    output logic          half,
    output logic          done,
    output logic          hie,
    output logic          die,
    output logic          irq
);
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic          en;
        logic          hie;
        logic          die;
        logic [1:0]    prio;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] rem;
        logic [CW-1:0] total;
        logic          half;
        logic          done;
    } cfg_t;

    cfg_t r_d, r_q;
    logic [CW-1:0] rem_dec;

    always_comb begin
        r_d     = r_q;
        rem_dec = r_q.rem - ONE_C;
        if (cfg_we) begin
            case (cfg_addr)
                OFS_CTRL: begin
                    r_d.en = cfg_wdata[BIT_EN];
                    if (!r_q.en) begin
                        r_d.hie  = cfg_wdata[BIT_HIE];
                        r_d.die  = cfg_wdata[BIT_DIE];
                        r_d.prio = cfg_wdata[BIT_PRLO+:2];
                    end
                end
                OFS_SRC: if (!r_q.en) r_d.src = cfg_wdata[AW-1:0];
                OFS_DST: if (!r_q.en) r_d.dst = cfg_wdata[AW-1:0];
                OFS_CNT: if (!r_q.en) begin
                    r_d.rem   = cfg_wdata[CW-1:0];
                    r_d.total = cfg_wdata[CW-1:0];
                end
                OFS_STAT: begin
                    if (cfg_wdata[BIT_HALF]) r_d.half = 1'b0;
                    if (cfg_wdata[BIT_DONE]) r_d.done = 1'b0;
                end
                default: ;
            endcase
        end
        if (byte_done) begin
            r_d.dst = r_q.dst + ONE_A;
            r_d.rem = rem_dec;
            if (rem_dec == (r_q.total >> 1)) r_d.half = 1'b1;
            if (rem_dec == '0)               r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_CTRL: begin
                cfg_rdata[BIT_EN]      = r_q.en;
                cfg_rdata[BIT_HIE]     = r_q.hie;
                cfg_rdata[BIT_DIE]     = r_q.die;
                cfg_rdata[BIT_PRLO+:2] = r_q.prio;
            end
            OFS_SRC:  cfg_rdata[AW-1:0] = r_q.src;
            OFS_DST:  cfg_rdata[AW-1:0] = r_q.dst;
            OFS_CNT:  cfg_rdata[CW-1:0] = r_q.rem;
            OFS_STAT: begin
                cfg_rdata[BIT_HALF] = r_q.half;
                cfg_rdata[BIT_DONE] = r_q.done;
            end
            default: ;
        endcase
    end

    assign en   = r_q.en;
    assign src  = r_q.src;
    assign dst  = r_q.dst;
    assign rem  = r_q.rem;
    assign half = r_q.half;
    assign done = r_q.done;
    assign hie  = r_q.hie;
    assign die  = r_q.die;
    assign irq  = (r_q.half && r_q.hie) || (r_q.done && r_q.die);
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] rem,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_gnt,
    output logic          byte_done
);
    typedef struct packed {
        xfer_st_e   st;
        logic [7:0] data;
        logic       ack;
    } xfer_t;

    xfer_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ack   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src;
        mem_wdata = s_q.data;
        byte_done = 1'b0;
        case (s_q.st)
            ST_IDLE: if (en && (rem != '0) && periph_req) s_d.st = ST_RD;
            ST_RD: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    s_d.data = mem_rdata;
                    s_d.ack  = 1'b1;
                    s_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst;
                if (mem_gnt) begin
                    byte_done = 1'b1;
                    s_d.st    = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, data: '0, ack: 1'b0};
        else        s_q <= s_d;
    end

    assign periph_ack = s_q.ack;
endmodule

// File: rtl/dma_p2m_chan.sv
module dma_p2m_chan #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_gnt,
    output logic          irq
);
    logic          en, half, done, hie, die, byte_done;
    logic [AW-1:0] src, dst;
    logic [CW-1:0] rem;

    dmac_cfg #(.AW(AW), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .byte_done(byte_done),
        .en(en), .src(src), .dst(dst), .rem(rem), .half(half), .done(done),
        .hie(hie), .die(die), .irq(irq)
    );

    dmac_xfer #(.AW(AW), .CW(CW)) u_xfer (
        .clk(clk), .rst_n(rst_n), .en(en), .rem(rem), .src(src), .dst(dst),
        .periph_req(periph_req), .periph_ack(periph_ack), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .byte_done(byte_done)
    );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_addr,
    input logic [31:0]   cfg_wdata,
    input logic          periph_req,
    input logic          periph_ack,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_gnt,
    input logic          en,
    input logic [CW-1:0] rem,
    input logic [AW-1:0] src,
    input logic [AW-1:0] dst,
    input logic          byte_done,
    input logic          done
);
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(periph_req && en && (rem != '0))); // R2
    AST_NO_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(rem) != '0); // R6
    AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> mem_addr == src); // R3
    AST_ACK_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> $past(mem_req && !mem_we && mem_gnt)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack); // R4
    AST_WR_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_addr == dst); // R5
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> dst == $past(dst) + ONE_A); // R5
    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> rem == $past(rem) - ONE_C); // R6
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> rem == '0); // R7
    AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd4 && cfg_wdata[1] && !byte_done) |=> !done); // R10
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
endmodule

bind dma_p2m_chan dmac_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .periph_req(periph_req), .periph_ack(periph_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .en(en), .rem(rem), .src(src), .dst(dst), .byte_done(byte_done), .done(done)
);

// File: tb/sim_dma_p2m_chan.sv
module sim_dma_p2m_chan;
    localparam logic [31:0] SRC_A  = 32'h4000_0024;
    localparam logic [31:0] SRC_B  = 32'h4000_1004;
    localparam logic [31:0] DST_A  = 32'h2000_0010;
    localparam logic [31:0] DST_B  = 32'h2000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_gnt = 1'b0;
    logic        irq;

    int tests = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, ack_cnt = 0, bad_src = 0, bad_dst = 0;
    int ws = 0, wcnt = 0;
    logic [7:0]  periph_data = '0;
    logic [31:0] src_exp = '0;
    logic [31:0] dst_next = '0;
    logic [7:0]  mem_img [0:255];

    always #5 clk = ~clk;

    dma_p2m_chan u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
        .periph_ack(periph_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .irq(irq)
    );

    // memory and peripheral-side monitor, updated away from the active edge
    always @(negedge clk) begin
        if (periph_ack) ack_cnt++;
        if (!rst_n || !mem_req) begin
            mem_gnt = 1'b0;
            wcnt    = 0;
        end else if (wcnt >= ws) begin
            mem_gnt = 1'b1;
            wcnt    = 0;
            if (mem_we) begin
                mem_img[mem_addr[7:0]] = mem_wdata;
                if (mem_addr != dst_next) bad_dst++;
                dst_next = mem_addr + 32'd1;
                wr_cnt++;
            end else begin
                mem_rdata = periph_data;
                if (mem_addr != src_exp) bad_src++;
                rd_cnt++;
            end
        end else begin
            mem_gnt = 1'b0;
            wcnt++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        tick();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        tick();
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic push_byte(input logic [7:0] v);
        int w0;
        w0 = wr_cnt;
        periph_data = v;
        periph_req = 1'b1;
        for (int i = 0; i < 200 && !periph_ack; i++) tick();
        periph_req = 1'b0;
        for (int i = 0; i < 200 && wr_cnt == w0; i++) tick();
        tick();
        tick();
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n, input logic [31:0] ctrl);
        cfg_write(3'd0, 32'h0);
        cfg_write(3'd4, 32'h3);
        cfg_write(3'd1, s);
        cfg_write(3'd2, d);
        cfg_write(3'd3, n);
        cfg_write(3'd0, ctrl);
        src_exp = s;
        dst_next = d;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        for (int a = 0; a < 5; a++) begin
            cfg_read(a[2:0], r);
            chk(r == 32'h0, "R1 reg reset", r, 32'h0);
        end
        chk(!mem_req && !periph_ack && !irq, "R1 outputs reset", {mem_req, periph_ack, irq}, 0);
    endtask

    task automatic t_disabled();
        int r0, a0;
        logic [31:0] r;
        cfg_write(3'd0, 32'h0000_0020);
        cfg_read(3'd0, r);
        chk(r == 32'h20, "R12 priority readback", r, 32'h20);
        cfg_write(3'd1, SRC_A);
        cfg_write(3'd3, 32'd3);
        r0 = rd_cnt; a0 = ack_cnt;
        periph_req = 1'b1;
        repeat (10) tick();
        periph_req = 1'b0;
        chk(rd_cnt == r0 && ack_cnt == a0, "R2 no access while disabled", rd_cnt - r0, 0);
        cfg_read(3'd3, r);
        chk(r == 32'd3, "R2 count untouched", r, 3);
    endtask

    task automatic t_basic();
        logic [31:0] r;
        int r0, a0;
        setup(SRC_A, DST_A, 4, 32'h7);
        a0 = ack_cnt;
        push_byte(8'hA1);
        cfg_read(3'd4, r);
        chk(r == 32'h0, "R8 no half after 1 of 4", r, 0);
        push_byte(8'hB2);
        cfg_read(3'd4, r);
        chk(r == 32'h1, "R8 half after 2 of 4", r, 1);
        chk(irq == 1'b1, "R9 irq from half", irq, 1);
        push_byte(8'hC3);
        cfg_read(3'd4, r);
        chk(r == 32'h1, "R7 done not before last", r, 1);
        push_byte(8'hD4);
        cfg_read(3'd4, r);
        chk(r == 32'h3, "R7 done after last", r, 3);
        chk({mem_img[8'h10], mem_img[8'h11], mem_img[8'h12], mem_img[8'h13]} == 32'hA1B2C3D4,
            "R5 buffer contents",
            {mem_img[8'h10], mem_img[8'h11], mem_img[8'h12], mem_img[8'h13]}, 32'hA1B2C3D4);
        chk(bad_dst == 0, "R5 write address sequence", bad_dst, 0);
        cfg_read(3'd2, r);
        chk(r == DST_A + 4, "R5 pointer readback", r, DST_A + 4);
        chk(bad_src == 0, "R3 read address fixed", bad_src, 0);
        chk(ack_cnt - a0 == 4, "R4 one ack per byte", ack_cnt - a0, 4);
        cfg_read(3'd3, r);
        chk(r == 32'd0, "R6 remaining zero", r, 0);
        r0 = rd_cnt; a0 = ack_cnt;
        periph_req = 1'b1;
        repeat (12) tick();
        periph_req = 1'b0;
        chk(rd_cnt == r0 && ack_cnt == a0, "R6 requests ignored at zero", rd_cnt - r0, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] r;
        cfg_write(3'd4, 32'h1);
        cfg_read(3'd4, r);
        chk(r == 32'h2, "R10 clear half only", r, 2);
        chk(irq == 1'b1, "R9 irq from done", irq, 1);
        cfg_write(3'd4, 32'h2);
        cfg_read(3'd4, r);
        chk(r == 32'h0, "R10 clear done", r, 0);
        chk(irq == 1'b0, "R9 irq low after clear", irq, 0);
    endtask

    task automatic t_locked();
        logic [31:0] r;
        setup(SRC_B, DST_B, 6, 32'h0000_0011);
        cfg_write(3'd1, 32'h1111_1111);
        cfg_write(3'd2, 32'h2222_2222);
        cfg_write(3'd3, 32'd9);
        cfg_write(3'd0, 32'h0000_0027);
        cfg_read(3'd1, r);
        chk(r == SRC_B, "R11 src locked", r, SRC_B);
        cfg_read(3'd2, r);
        chk(r == DST_B, "R11 dst locked", r, DST_B);
        cfg_read(3'd3, r);
        chk(r == 32'd6, "R11 count locked", r, 6);
        cfg_read(3'd0, r);
        chk(r == 32'h11, "R11 ctrl fields locked", r, 32'h11);
        cfg_write(3'd0, 32'h0);
        cfg_read(3'd0, r);
        chk(r == 32'h10, "R11 disable takes effect", r, 32'h10);
    endtask

    task automatic t_odd_waits();
        logic [31:0] r;
        ws = 2;
        setup(SRC_B, DST_B, 5, 32'h3);
        push_byte(8'h01);
        push_byte(8'h02);
        cfg_read(3'd4, r);
        chk(r == 32'h0, "R8 no half after 2 of 5", r, 0);
        push_byte(8'h03);
        cfg_read(3'd4, r);
        chk(r == 32'h1, "R8 half after 3 of 5", r, 1);
        push_byte(8'h04);
        push_byte(8'h05);
        cfg_write(3'd4, 32'h1);
        cfg_read(3'd4, r);
        chk(r == 32'h2 && irq == 1'b0, "R9 done masked", {r[30:0], irq}, 32'h4);
        chk(mem_img[8'h84] == 8'h05 && bad_src == 0, "R3 R5 wait-state transfer", mem_img[8'h84], 5);
        ws = 0;
    endtask

    task automatic t_one();
        logic [31:0] r;
        setup(SRC_A, DST_A, 1, 32'h5);
        push_byte(8'h5A);
        cfg_read(3'd4, r);
        chk(r == 32'h3, "R8 R7 count one sets both", r, 3);
        chk(irq == 1'b1, "R9 irq done enabled", irq, 1);
        chk(mem_img[8'h10] == 8'h5A, "R5 single byte", mem_img[8'h10], 8'h5A);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        t_basic();
        t_w1c();
        t_locked();
        t_odd_waits();
        t_one();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule